// File: doc/BRIEF.md
# I2C Register Target with Per-Byte CRC

This block is an I2C target that gives a bus controller access to a byte-addressed register file inside the chip. It watches the open-drain SCL and SDA lines through input pins and pulls them low through output-enable pins. It finds START, repeated START and STOP conditions. It answers only to its configured 7-bit address. A write carries a register index followed by any number of data bytes. A read returns consecutive register contents until the controller declines a byte. The register index moves forward by one after every data byte in both directions.

When the integrity option is on, a CRC-8 byte follows each data byte. The target checks this byte on writes and generates it on reads. A write is committed to the register file only after its check byte matches. A mismatch is refused with a NACK, and the target drops out of the transaction. Read data comes from the register file through a request/valid port. If that data is not ready when the next byte must start, the target holds SCL low until it arrives.

Top module: `i2c_crc_target`

## Requirements
- R1: While reset is active and right after it is released, the target drives neither line low (`sda_oe` and `scl_oe` are 0) and issues no register-file strobe. `rf_we` and `rf_re` are never high in the same cycle.
- R2: The target ACKs an address byte only when its upper seven bits equal `cfg_addr`; bit 0 set means read. With `cfg_addr` = 0x08 the address bytes are 0x10 (write) and 0x11 (read). Any other address, and every byte after it until the next START, is NACKed and touches no register.
- R3: In a write, the first byte after the address sets the register index. Every following data byte is written to the current index, which then increments by one. Any number of data bytes may be sent before STOP.
- R4: In a read, the target returns the byte at the current index and increments the index. It keeps returning consecutive bytes while the controller ACKs, and releases SDA after a NACK. A later read continues from the incremented index.
- R5: The register index set by a write is kept for a read that follows either with a repeated START or with a STOP and a new START.
- R6: With `cfg_crc_en` = 1, each write data byte is followed by a CRC-8 byte (polynomial 0x07, MSB first, initial value 0x00). The first one covers the address byte, the index byte and the first data byte. Each later one covers only its own data byte. A matching CRC is ACKed and the data byte is then written.
- R7: With `cfg_crc_en` = 1, a write CRC byte that does not match is NACKed and its data byte is not written. The target then NACKs every byte until the next START.
- R8: With `cfg_crc_en` = 1, each read data byte is followed by a CRC byte. The first one covers the read address byte and the first data byte; each later one covers only its own data byte. A NACK on a CRC byte ends the read.
- R9: When read data is not yet valid at the point where the next byte must begin, the target holds SCL low until the data arrives. It changes its SDA drive only while SCL is low.
- R10: A START or STOP in the middle of a byte abandons that byte without any register access. After a START, the target expects a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_addr | input | 7 | Own 7-bit bus address |
| cfg_crc_en | input | 1 | Enables the per-byte CRC-8 byte |
| rf_addr | output | PTR_W | Register-file index for a write or read request |
| rf_we | output | 1 | One-cycle register write strobe |
| rf_wdata | output | 8 | Register write data |
| rf_re | output | 1 | One-cycle register read request |
| rf_rdata | input | 8 | Register read data |
| rf_rvalid | input | 1 | `rf_rdata` is valid in this cycle |

## Verification
The main function is tried with block writes of several bytes and with reads closed by a repeated START and by a STOP/START pair. These show whether the index is kept between phases and advanced once per byte. Addressing is tried with a foreign address, with the old address after `cfg_addr` changes, and with the new address, so that a wrong match is caught in either direction. CRC traffic covers a good first and later check byte, a corrupted one followed by further bytes, and multi-byte reads whose check bytes are compared against values the bench computes. A slow register file forces clock stretching. Transfers cut short mid-byte by STOP and by repeated START show that partial bytes cause no register access.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_WAIT
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_REG, PH_DATA, PH_CRC
  } tgt_phase_e;
endpackage

// File: rtl/i2c_tgt_rst_sync.sv
module i2c_tgt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_tgt_line_sync.sv
module i2c_tgt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_o    = scl_p[STAGES-1];
  assign sda_o    = sda_p[STAGES-1];
  assign scl_rise = scl_o & ~scl_d;
  assign scl_fall = ~scl_o & scl_d;
  assign start_o  = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o   = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_tgt_crc8.sv
module i2c_tgt_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic [7:0] crc_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  always_comb begin
    crc_o = crc_i ^ data_i;
    for (int i = 0; i < 8; i++) begin
      crc_o = crc_o[7] ? ((crc_o << 1) ^ POLY) : (crc_o << 1);
    end
  end
endmodule

// File: rtl/i2c_crc_target.sv
module i2c_crc_target
  import i2c_tgt_pkg::*;
#(
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CRC_POLY    = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic [6:0]       cfg_addr,
  input  logic             cfg_crc_en,
  output logic [PTR_W-1:0] rf_addr,
  output logic             rf_we,
  output logic [7:0]       rf_wdata,
  output logic             rf_re,
  input  logic [7:0]       rf_rdata,
  input  logic             rf_rvalid
);
  localparam logic [3:0] BITS = 4'd8;

  logic srst_n;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_tgt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(srst_n));

  i2c_tgt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(srst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_o(start_det), .stop_o(stop_det));

  tgt_state_e       state_q, state_d;
  tgt_phase_e       phase_q, phase_d;
  logic [3:0]       bitcnt_q, bitcnt_d;
  logic [7:0]       shreg_q, shreg_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [7:0]       crc_q, crc_d;
  logic [7:0]       wbuf_q, wbuf_d;
  logic [7:0]       rbuf_q, rbuf_d;
  logic             rbuf_ok_q, rbuf_ok_d;
  logic             rw_q, rw_d;
  logic             ack_ok_q, ack_ok_d;
  logic             mack_q, mack_d;
  logic             sda_oe_q, sda_oe_d;
  logic             scl_oe_q, scl_oe_d;
  logic [PTR_W-1:0] rf_addr_q, rf_addr_d;
  logic             rf_we_q, rf_we_d;
  logic [7:0]       rf_wdata_q, rf_wdata_d;
  logic             rf_re_q, rf_re_d;
  logic             need_byte;
  logic [7:0]       crc_in_byte, crc_next;
  logic             st_idle;

  // CRC folds either the received byte or the byte being loaded for transmit
  assign crc_in_byte = (state_q == ST_RX) ? shreg_q : rbuf_q;

  i2c_tgt_crc8 #(.POLY(CRC_POLY)) u_crc (
    .crc_i(crc_q), .data_i(crc_in_byte), .crc_o(crc_next));

  always_comb begin
    state_d    = state_q;
    phase_d    = phase_q;
    bitcnt_d   = bitcnt_q;
    shreg_d    = shreg_q;
    ptr_d      = ptr_q;
    crc_d      = crc_q;
    wbuf_d     = wbuf_q;
    rbuf_d     = rbuf_q;
    rbuf_ok_d  = rbuf_ok_q;
    rw_d       = rw_q;
    ack_ok_d   = ack_ok_q;
    mack_d     = mack_q;
    sda_oe_d   = sda_oe_q;
    rf_addr_d  = rf_addr_q;
    rf_wdata_d = rf_wdata_q;
    rf_we_d    = 1'b0;
    rf_re_d    = 1'b0;
    scl_oe_d   = (state_q == ST_WAIT);
    need_byte  = 1'b0;

    if (rf_rvalid) begin
      rbuf_d    = rf_rdata;
      rbuf_ok_d = 1'b1;
    end

    if (start_det) begin
      state_d  = ST_RX;
      phase_d  = PH_ADDR;
      bitcnt_d = '0;
      crc_d    = '0;
      sda_oe_d = 1'b0;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
      sda_oe_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && bitcnt_q != BITS) begin
            shreg_d  = {shreg_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end
          if (scl_fall && bitcnt_q == BITS) begin
            state_d  = ST_RX_ACK;
            sda_oe_d = 1'b1;
            ack_ok_d = 1'b1;
            unique case (phase_q)
              PH_ADDR: begin
                if (shreg_q[7:1] == cfg_addr) begin
                  rw_d  = shreg_q[0];
                  crc_d = crc_next;
                  if (shreg_q[0]) begin
                    rf_addr_d = ptr_q;
                    rf_re_d   = 1'b1;
                    rbuf_ok_d = 1'b0;
                  end
                end else begin
                  state_d  = ST_IDLE;
                  sda_oe_d = 1'b0;
                end
              end
              PH_REG: begin
                ptr_d = PTR_W'(shreg_q);
                crc_d = crc_next;
              end
              PH_DATA: begin
                crc_d = crc_next;
                if (cfg_crc_en) begin
                  wbuf_d = shreg_q;
                end else begin
                  rf_addr_d  = ptr_q;
                  rf_wdata_d = shreg_q;
                  rf_we_d    = 1'b1;
                  ptr_d      = ptr_q + 1'b1;
                end
              end
              PH_CRC: begin
                crc_d = '0;
                if (shreg_q == crc_q) begin
                  rf_addr_d  = ptr_q;
                  rf_wdata_d = wbuf_q;
                  rf_we_d    = 1'b1;
                  ptr_d      = ptr_q + 1'b1;
                end else begin
                  sda_oe_d = 1'b0;
                  ack_ok_d = 1'b0;
                end
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            sda_oe_d = 1'b0;
            bitcnt_d = '0;
            state_d  = ST_RX;
            if (!ack_ok_q) begin
              state_d = ST_IDLE;
            end else begin
              unique case (phase_q)
                PH_ADDR: if (rw_q) need_byte = 1'b1;
                         else      phase_d   = PH_REG;
                PH_REG:  phase_d = PH_DATA;
                PH_DATA: phase_d = cfg_crc_en ? PH_CRC : PH_DATA;
                PH_CRC:  phase_d = PH_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == BITS) begin
              sda_oe_d = 1'b0;
              state_d  = ST_TX_ACK;
              if (phase_q == PH_DATA) begin
                rf_addr_d = ptr_q;
                rf_re_d   = 1'b1;
                rbuf_ok_d = 1'b0;
              end
            end else begin
              sda_oe_d = ~shreg_q[6];
              shreg_d  = {shreg_q[6:0], 1'b0};
              bitcnt_d = bitcnt_q + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack_d = ~sda_s;
          if (scl_fall) begin
            if (!mack_q) begin
              state_d = ST_IDLE;
            end else if (phase_q == PH_DATA && cfg_crc_en) begin
              state_d  = ST_TX;
              phase_d  = PH_CRC;
              shreg_d  = crc_q;
              sda_oe_d = ~crc_q[7];
              bitcnt_d = 4'd1;
              crc_d    = '0;
            end else begin
              need_byte = 1'b1;
            end
          end
        end
        ST_WAIT: need_byte = rbuf_ok_q;
        default: ;
      endcase
    end

    if (need_byte) begin
      if (rbuf_ok_q) begin
        state_d   = ST_TX;
        phase_d   = PH_DATA;
        shreg_d   = rbuf_q;
        sda_oe_d  = ~rbuf_q[7];
        bitcnt_d  = 4'd1;
        ptr_d     = ptr_q + 1'b1;
        crc_d     = crc_next;
        rbuf_ok_d = rf_rvalid;
      end else begin
        state_d  = ST_WAIT;
        sda_oe_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_ADDR;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      ptr_q      <= '0;
      crc_q      <= '0;
      wbuf_q     <= '0;
      rbuf_q     <= '0;
      rbuf_ok_q  <= 1'b0;
      rw_q       <= 1'b0;
      ack_ok_q   <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_q   <= 1'b0;
      scl_oe_q   <= 1'b0;
      rf_addr_q  <= '0;
      rf_we_q    <= 1'b0;
      rf_wdata_q <= '0;
      rf_re_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      phase_q    <= phase_d;
      bitcnt_q   <= bitcnt_d;
      shreg_q    <= shreg_d;
      ptr_q      <= ptr_d;
      crc_q      <= crc_d;
      wbuf_q     <= wbuf_d;
      rbuf_q     <= rbuf_d;
      rbuf_ok_q  <= rbuf_ok_d;
      rw_q       <= rw_d;
      ack_ok_q   <= ack_ok_d;
      mack_q     <= mack_d;
      sda_oe_q   <= sda_oe_d;
      scl_oe_q   <= scl_oe_d;
      rf_addr_q  <= rf_addr_d;
      rf_we_q    <= rf_we_d;
      rf_wdata_q <= rf_wdata_d;
      rf_re_q    <= rf_re_d;
    end
  end

  assign st_idle  = (state_q == ST_IDLE);
  assign sda_oe   = sda_oe_q;
  assign scl_oe   = scl_oe_q;
  assign rf_addr  = rf_addr_q;
  assign rf_we    = rf_we_q;
  assign rf_wdata = rf_wdata_q;
  assign rf_re    = rf_re_q;
endmodule

// File: rtl/i2c_crc_target_chk.sv
module i2c_crc_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic scl_oe,
  input logic rf_we,
  input logic rf_re,
  input logic st_idle
);
  // R1: write and read strobes never coincide
  a_r1_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && rf_re));

  // R2: an idle target neither drives SDA nor writes a register
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> (!sda_oe && !rf_we));

  // R3: each committed byte gives exactly one write strobe
  a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  // R4: each fetch is a single request cycle
  a_r4_re_single: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |=> !rf_re);

  // R9: SDA drive is frozen while SCL stays high
  a_r9_sda_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R9: stretching begins only in the low phase of SCL
  a_r9_stretch_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !scl_s);
endmodule

bind i2c_crc_target i2c_crc_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .scl_oe(scl_oe), .rf_we(rf_we), .rf_re(rf_re), .st_idle(st_idle));

// File: tb/i2c_crc_target_test.sv
module i2c_crc_target_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, m_scl, m_sda, cfg_crc_en;
  logic [6:0] cfg_addr;
  logic       bus_scl, bus_sda, scl_oe, sda_oe;
  logic [7:0] rf_addr, rf_wdata, rf_rdata;
  logic       rf_we, rf_re, rf_rvalid;

  assign bus_scl = m_scl & ~scl_oe;
  assign bus_sda = m_sda & ~sda_oe;

  i2c_crc_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(bus_scl), .sda_i(bus_sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_addr(cfg_addr),
    .cfg_crc_en(cfg_crc_en), .rf_addr(rf_addr), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .rf_re(rf_re), .rf_rdata(rf_rdata),
    .rf_rvalid(rf_rvalid));

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 7 + 3) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] crc8(logic [7:0] c, logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  // register-file model
  logic [7:0] mem [256];
  int         lat = 2;
  int         rcnt;
  logic       pend;
  logic [7:0] paddr;
  int         stretch_cnt;

  always @(posedge clk) begin
    rf_rvalid <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      pend <= 1'b0;
      stretch_cnt <= 0;
    end else begin
      if (scl_oe) stretch_cnt <= stretch_cnt + 1;
      if (rf_we) mem[rf_addr] <= rf_wdata;
      if (rf_re) begin
        pend <= 1'b1; rcnt <= lat; paddr <= rf_addr;
      end else if (pend) begin
        if (rcnt <= 1) begin
          rf_rvalid <= 1'b1; rf_rdata <= mem[paddr]; pend <= 1'b0;
        end else rcnt <= rcnt - 1;
      end
    end
  end

  // scoreboard
  typedef struct { string req; int val; } item_t;
  item_t exp_q[$];
  int    obs_q[$];
  int    total = 0, bad = 0;
  bit    finished = 0;

  always @(negedge clk) begin
    if (exp_q.size() > 0 && obs_q.size() > 0) begin
      item_t e;
      int o;
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      total++;
      if (e.val != o) begin
        bad++;
        $display("FAIL %s: got %0h expected %0h", e.req, o, e.val);
      end
    end
  end

  task automatic check(string req, int got, int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, expv);
    end
  endtask

  // bus controller model
  task automatic tq(); repeat (10) @(negedge clk); endtask
  task automatic scl_up();
    m_scl = 1'b1;
    do @(negedge clk); while (bus_scl !== 1'b1);
    tq();
  endtask
  task automatic i2c_start(); m_sda = 1'b1; tq(); scl_up(); m_sda = 1'b0; tq(); m_scl = 1'b0; tq(); endtask
  task automatic i2c_stop(); m_sda = 1'b0; tq(); scl_up(); m_sda = 1'b1; tq(); endtask
  task automatic put_bit(bit b); m_sda = b; tq(); scl_up(); m_scl = 1'b0; tq(); endtask
  task automatic get_bit(output bit b); m_sda = 1'b1; tq(); scl_up(); b = bus_sda; m_scl = 1'b0; tq(); endtask

  task automatic wr_chk(string req, logic [7:0] b, bit exp_nack);
    bit n;
    exp_q.push_back('{req, int'(exp_nack)});
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(n);
    obs_q.push_back(int'(n));
  endtask

  task automatic rd_chk(string req, bit last, logic [7:0] expv);
    logic [7:0] v = '0;
    bit b;
    exp_q.push_back('{req, int'(expv)});
    for (int i = 0; i < 8; i++) begin get_bit(b); v = {v[6:0], b}; end
    put_bit(last);
    obs_q.push_back(int'(v));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s0;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    cfg_addr = 7'h08; cfg_crc_en = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 reset sda", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 sda_oe", int'(sda_oe), 0);
    check("R1 scl_oe", int'(scl_oe), 0);
    check("R1 strobes", int'(rf_we | rf_re), 0);

    // R3 block write, R5 repeated-start read, R4 sequential read
    i2c_start(); wr_chk("R2 addr ack", 8'h10, 0); wr_chk("R3 index", 8'h20, 0);
    wr_chk("R3 d0", 8'hA1, 0); wr_chk("R3 d1", 8'hB2, 0); wr_chk("R3 d2", 8'hC3, 0);
    i2c_stop();
    check("R3 mem20", int'(mem[8'h20]), 'hA1);
    check("R3 mem22", int'(mem[8'h22]), 'hC3);
    i2c_start(); wr_chk("R5 addr", 8'h10, 0); wr_chk("R5 index", 8'h20, 0);
    i2c_start(); wr_chk("R5 raddr", 8'h11, 0);
    rd_chk("R4 r0", 0, 8'hA1); rd_chk("R4 r1", 0, 8'hB2); rd_chk("R4 r2", 1, 8'hC3);
    i2c_stop();
    i2c_start(); wr_chk("R4 raddr", 8'h11, 0); rd_chk("R4 continue", 1, init_val(8'h23)); i2c_stop();

    // R5 stop then start
    i2c_start(); wr_chk("R5 addr", 8'h10, 0); wr_chk("R5 index", 8'h21, 0); i2c_stop();
    i2c_start(); wr_chk("R5 raddr", 8'h11, 0);
    rd_chk("R5 r0", 0, 8'hB2); rd_chk("R5 r1", 1, 8'hC3); i2c_stop();

    // R2 address matching
    i2c_start(); wr_chk("R2 foreign nack", 8'h22, 1);
    wr_chk("R2 ignored", 8'h20, 1); wr_chk("R2 ignored", 8'h99, 1); i2c_stop();
    check("R2 mem untouched", int'(mem[8'h20]), 'hA1);
    cfg_addr = 7'h3A;
    i2c_start(); wr_chk("R2 old addr nack", 8'h10, 1); i2c_stop();
    i2c_start(); wr_chk("R2 new addr ack", 8'h74, 0); wr_chk("R2 index", 8'h30, 0);
    wr_chk("R2 data", 8'h5C, 0); i2c_stop();
    check("R2 mem30", int'(mem[8'h30]), 'h5C);
    cfg_addr = 7'h08;

    // R6 CRC write
    cfg_crc_en = 1'b1;
    i2c_start(); wr_chk("R6 addr", 8'h10, 0); wr_chk("R6 index", 8'h40, 0);
    wr_chk("R6 d0", 8'h5A, 0);
    wr_chk("R6 crc0", crc8(crc8(crc8(8'h00, 8'h10), 8'h40), 8'h5A), 0);
    wr_chk("R6 d1", 8'h6B, 0); wr_chk("R6 crc1", crc8(8'h00, 8'h6B), 0);
    i2c_stop();
    check("R6 mem40", int'(mem[8'h40]), 'h5A);
    check("R6 mem41", int'(mem[8'h41]), 'h6B);

    // R7 bad CRC
    i2c_start(); wr_chk("R7 addr", 8'h10, 0); wr_chk("R7 index", 8'h50, 0);
    wr_chk("R7 data", 8'h11, 0);
    wr_chk("R7 bad crc nack", crc8(crc8(crc8(8'h00, 8'h10), 8'h50), 8'h11) ^ 8'h01, 1);
    wr_chk("R7 idle nack", 8'h22, 1); i2c_stop();
    check("R7 mem50 kept", int'(mem[8'h50]), int'(init_val(8'h50)));

    // R8 CRC read
    i2c_start(); wr_chk("R8 addr", 8'h10, 0); wr_chk("R8 index", 8'h50, 0);
    i2c_start(); wr_chk("R8 raddr", 8'h11, 0);
    rd_chk("R8 d0", 0, init_val(8'h50));
    rd_chk("R8 crc0", 0, crc8(crc8(8'h00, 8'h11), init_val(8'h50)));
    rd_chk("R8 d1", 0, init_val(8'h51));
    rd_chk("R8 crc1", 0, crc8(8'h00, init_val(8'h51)));
    rd_chk("R8 d2", 0, init_val(8'h52));
    rd_chk("R8 crc2", 1, crc8(8'h00, init_val(8'h52)));
    i2c_stop();
    cfg_crc_en = 1'b0;

    // R9 clock stretch with a slow register file
    lat = 60;
    s0 = stretch_cnt;
    i2c_start(); wr_chk("R9 addr", 8'h10, 0); wr_chk("R9 index", 8'h20, 0);
    i2c_start(); wr_chk("R9 raddr", 8'h11, 0);
    rd_chk("R9 r0", 0, 8'hA1); rd_chk("R9 r1", 1, 8'hB2); i2c_stop();
    check("R9 stretched", int'(stretch_cnt > s0), 1);
    lat = 2;

    // R10 abandoned bytes
    i2c_start(); wr_chk("R10 addr", 8'h10, 0); wr_chk("R10 index", 8'h60, 0);
    wr_chk("R10 data", 8'h77, 0);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    i2c_stop();
    check("R10 mem60", int'(mem[8'h60]), 'h77);
    check("R10 mem61 kept", int'(mem[8'h61]), int'(init_val(8'h61)));
    i2c_start(); wr_chk("R10 addr", 8'h10, 0);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    i2c_start(); wr_chk("R10 readdr", 8'h10, 0); wr_chk("R10 index", 8'h62, 0);
    wr_chk("R10 data", 8'h88, 0); i2c_stop();
    check("R10 mem62", int'(mem[8'h62]), 'h88);

    repeat (20) @(negedge clk);
    check("scoreboard drained", exp_q.size() + obs_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule